// File: doc/BRIEF.md
# USB Host Interrupt Controller

This block collects the event strobes of a small USB host controller and turns them into one level-sensitive interrupt request for an external CPU. Each event sets a bit in a sticky status register. An enable register picks which of those bits may drive the request line. Software reaches both registers, a two-bit control register and the reload value of a frame timer through a byte-wide register port. Reads return data combinationally in the cycle the read strobe is high.

The event sources are:

- Done strobes from the two transfer channels.
- A device attach/detach strobe.
- One shared bit that is fed either by a device-detection strobe or by a resume-detect strobe. A control bit chooses which one.
- An internal start-of-frame interval timer. It is a down-counter advanced by a 12 MHz clock-enable tick and reloaded from a programmable value. With a reload value of 11999 it produces one event per millisecond.

Top module: `usbh_irq_ctrl`

## Requirements
- R1: After reset the control, enable, status and reload registers read 0 and `irq` is low.
- R2: Status bit mapping:
  - A `done_a` pulse sets status bit 0.
  - A `done_b` pulse sets status bit 1.
  - A `plug_evt` pulse sets bit 5.
  - Each of these is set whether or not the matching enable bit is 1.
- R3: `irq` is high while any status bit is 1 with its enable bit also 1. It stays high until every such bit is cleared or disabled.
- R4: Writing 1 to a status bit position (address 0Dh) clears that bit. Writing 0 leaves the bit unchanged.
- R5: When an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R6: Control bit 6 (address 05h) selects the source of status bit 6:
  - When it is 1, `resume_evt` sets bit 6 and `detect_evt` is ignored.
  - When it is 0, `detect_evt` sets bit 6 and `resume_evt` is ignored.
- R7: Frame timer period:
  - The timer runs when control bit 0 is 1 and the reload value N ({0Fh[5:0], 0Eh}) is nonzero.
  - It sets status bit 4 once every N+1 ticks.
  - The first event comes N+1 ticks after the control bit is set.
- R8: Writing control bit 0 to 0 stops the timer and holds it at the reload value. Setting the bit again starts a full period.
- R9: Read and write rules:
  - Reserved bits read 0 and ignore writes. The enable register keeps only bits 0, 1, 4, 5 and 6. The control register keeps only bits 0 and 6. Address 0Fh keeps only bits 5:0.
  - `rdata` is 0 when `rd` is low or the address is unmapped.
- R10: Register map:
  - 05h is the control register.
  - 06h is the enable register.
  - 0Dh is the status register.
  - 0Eh holds the reload low byte.
  - 0Fh holds the reload high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd` is high |
| tick | input | 1 | 12 MHz clock-enable for the frame timer |
| done_a | input | 1 | Channel A transfer done strobe |
| done_b | input | 1 | Channel B transfer done strobe |
| plug_evt | input | 1 | Device attach/detach strobe |
| detect_evt | input | 1 | Device detection strobe |
| resume_evt | input | 1 | Resume detect strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 14-bit timer and a combinational interrupt output. It programs small reload values, so full timer periods, wrap reloads and stop/restart sequences all happen within tens of cycles, both with a tick on every cycle and with a tick on every other cycle. With a 14-bit counter the high reload register keeps exactly six bits, so writing all ones to address 0Fh shows the masking of the reserved bits.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
   localparam logic [7:0] ADDR_CTRL   = 8'h05;
   localparam logic [7:0] ADDR_IEN    = 8'h06;
   localparam logic [7:0] ADDR_ISTAT  = 8'h0D;
   localparam logic [7:0] ADDR_SOF_LO = 8'h0E;
   localparam logic [7:0] ADDR_SOF_HI = 8'h0F;

   localparam int BIT_DONE_A = 0;
   localparam int BIT_DONE_B = 1;
   localparam int BIT_SOF    = 4;
   localparam int BIT_PLUG   = 5;
   localparam int BIT_DETRES = 6;

   localparam logic [7:0] IRQ_IMPL_MASK = 8'h73;

   localparam int CTRL_SOF_RUN = 0;
   localparam int CTRL_RES_SEL = 6;
endpackage

// File: rtl/usbh_sof_timer.sv
module usbh_sof_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic             sof_pulse
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= reload;
      else if (tick)
         cnt <= (cnt == '0) ? reload : cnt - 1'b1;
   end

   assign sof_pulse = run && tick && (cnt == '0);

   // R8: a stopped timer sits at the reload value
   a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == $past(reload));

   // R7: every frame event reloads the counter
   a_r7_reload_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |=> cnt == $past(reload));
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status #(
   parameter int         W    = 8,
   parameter logic [7:0] IMPL = 8'h73
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_evt,
   input  logic [W-1:0] clr_req,
   output logic [W-1:0] status
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               status[i] <= 1'b0;
            else if (set_evt[i])
               status[i] <= 1'b1;
            else if (clr_req[i])
               status[i] <= 1'b0;
         end

         // R2 and R5: an event always leaves its bit set
         a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> status[i]);

         // R4: a clear without a competing event drops the bit
         a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && !set_evt[i]) |=> !status[i]);
      end else begin : g_tied
         assign status[i] = 1'b0;
      end
   end
endmodule

// File: rtl/usbh_irq_regs.sv
module usbh_irq_regs
   import usbh_irq_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   input  logic [7:0]       status,
   output logic [7:0]       rdata,
   output logic             sof_run,
   output logic             res_sel,
   output logic [7:0]       ien,
   output logic [CNT_W-1:0] reload,
   output logic [7:0]       stat_clr
);
   localparam int HI_W  = CNT_W - 8;
   localparam int PAD_W = 8 - HI_W;

   logic [7:0]      rl_lo;
   logic [HI_W-1:0] rl_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sof_run <= 1'b0;
         res_sel <= 1'b0;
         ien     <= '0;
         rl_lo   <= '0;
         rl_hi   <= '0;
      end else if (wr) begin
         case (addr)
            ADDR_CTRL: begin
               sof_run <= wdata[CTRL_SOF_RUN];
               res_sel <= wdata[CTRL_RES_SEL];
            end
            ADDR_IEN:    ien   <= wdata & IRQ_IMPL_MASK;
            ADDR_SOF_LO: rl_lo <= wdata;
            ADDR_SOF_HI: rl_hi <= wdata[HI_W-1:0];
            default: ;
         endcase
      end
   end

   assign reload   = {rl_hi, rl_lo};
   assign stat_clr = (wr && addr == ADDR_ISTAT) ? wdata : 8'h00;

   always_comb begin
      rdata = 8'h00;
      if (rd) begin
         case (addr)
            ADDR_CTRL: begin
               rdata[CTRL_SOF_RUN] = sof_run;
               rdata[CTRL_RES_SEL] = res_sel;
            end
            ADDR_IEN:    rdata = ien;
            ADDR_ISTAT:  rdata = status;
            ADDR_SOF_LO: rdata = rl_lo;
            ADDR_SOF_HI: rdata = {{PAD_W{1'b0}}, rl_hi};
            default:     rdata = 8'h00;
         endcase
      end
   end

   // R9: reserved enable bits never hold a 1
   a_r9_ien_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (ien & ~IRQ_IMPL_MASK) == 8'h00);
endmodule

// File: rtl/usbh_irq_ctrl.sv
module usbh_irq_ctrl
   import usbh_irq_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       rd,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       tick,
   input  logic       done_a,
   input  logic       done_b,
   input  logic       plug_evt,
   input  logic       detect_evt,
   input  logic       resume_evt,
   output logic       irq
);
   if (CNT_W < 9 || CNT_W > 15) begin : g_bad_cnt_w
      $error("usbh_irq_ctrl: CNT_W must lie in 9..15");
   end

   logic             sof_run, res_sel, sof_pulse;
   logic [7:0]       ien, status, stat_clr, evt;
   logic [CNT_W-1:0] reload;
   logic             pending;

   usbh_irq_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr),
      .wdata(wdata), .status(status), .rdata(rdata), .sof_run(sof_run),
      .res_sel(res_sel), .ien(ien), .reload(reload), .stat_clr(stat_clr)
   );

   usbh_sof_timer #(.CNT_W(CNT_W)) u_sof (
      .clk(clk), .rst_n(rst_n), .run(sof_run && (reload != '0)),
      .tick(tick), .reload(reload), .sof_pulse(sof_pulse)
   );

   always_comb begin
      evt             = 8'h00;
      evt[BIT_DONE_A] = done_a;
      evt[BIT_DONE_B] = done_b;
      evt[BIT_SOF]    = sof_pulse;
      evt[BIT_PLUG]   = plug_evt;
      evt[BIT_DETRES] = res_sel ? resume_evt : detect_evt;
   end

   usbh_irq_status #(.W(8), .IMPL(IRQ_IMPL_MASK)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_evt(evt), .clr_req(stat_clr),
      .status(status)
   );

   assign pending = |(status & ien);

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= pending;
      end
   end else begin : g_irq_comb
      assign irq = pending;

      // R3: without a write to status or enable the request cannot drop
      a_r3_irq_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (irq && !(wr && (addr == ADDR_ISTAT || addr == ADDR_IEN))) |=> irq);
   end

   // R9: unimplemented status bits stay 0
   a_r9_status_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~IRQ_IMPL_MASK) == 8'h00);

   // R6: the unselected source never sets bit 6
   a_r6_unselected_src: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[BIT_DETRES] && !(res_sel ? resume_evt : detect_evt))
      |=> !status[BIT_DETRES]);
endmodule

// File: tb/usbh_irq_ctrl_test.sv
module usbh_irq_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] addr = 8'h00, wdata = 8'h00;
   logic [7:0] rdata;
   logic       tick = 1'b1;
   logic       done_a = 1'b0, done_b = 1'b0, plug_evt = 1'b0;
   logic       detect_evt = 1'b0, resume_evt = 1'b0;
   logic       irq;
   logic       slow_tick = 1'b0;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   usbh_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tick(tick), .done_a(done_a), .done_b(done_b),
      .plug_evt(plug_evt), .detect_evt(detect_evt), .resume_evt(resume_evt),
      .irq(irq)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      #1 tick <= slow_tick ? ~tick : 1'b1;
   end

   // reference model
   int m_ctrl, m_ien, m_stat, m_reload, m_cnt;
   int n_cnt, evt, clr;
   bit run_o, sof;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_ien = 0; m_stat = 0; m_reload = 0; m_cnt = 0;
      end else begin
         run_o = (m_ctrl & 1) != 0 && m_reload != 0;
         sof = run_o && tick && m_cnt == 0;
         if (!run_o) n_cnt = m_reload;
         else if (tick) n_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1;
         else n_cnt = m_cnt;
         evt = 0;
         if (done_a) evt |= 1;
         if (done_b) evt |= 2;
         if (sof) evt |= 16;
         if (plug_evt) evt |= 32;
         if ((m_ctrl & 64) != 0 ? resume_evt : detect_evt) evt |= 64;
         clr = (wr && addr == 8'h0D) ? int'(wdata) : 0;
         m_stat = ((m_stat & ~clr) | evt) & 8'h73;
         m_cnt = n_cnt;
         if (wr) begin
            case (addr)
               8'h05: m_ctrl = wdata & 8'h41;
               8'h06: m_ien = wdata & 8'h73;
               8'h0E: m_reload = (m_reload & 16'h3F00) | wdata;
               8'h0F: m_reload = (m_reload & 16'h00FF) | ((wdata & 8'h3F) << 8);
               default: ;
            endcase
         end
      end
   end

   function automatic int m_read();
      if (!rd) return 0;
      case (addr)
         8'h05: return m_ctrl;
         8'h06: return m_ien;
         8'h0D: return m_stat;
         8'h0E: return m_reload & 255;
         8'h0F: return m_reload >> 8;
         default: return 0;
      endcase
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R3 model irq", 16'(irq), 16'((m_stat & m_ien) != 0));
         chk("R9 model rdata", 16'(rdata), 16'(m_read()));
      end
   end

   task automatic wr_reg(logic [7:0] a, logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #1 wr = 1'b0;
   endtask

   task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
      addr = a; rd = 1'b1;
      @(negedge clk); chk(req, 16'(rdata), 16'(exp));
      @(posedge clk); #1 rd = 1'b0;
   endtask

   task automatic irq_chk(logic exp, string req);
      @(negedge clk); chk(req, 16'(irq), 16'(exp));
      @(posedge clk); #1;
   endtask

   // which: bit0 done_a, bit1 done_b, bit2 plug, bit3 detect, bit4 resume
   task automatic pulse(logic [4:0] which);
      {resume_evt, detect_evt, plug_evt, done_b, done_a} = which;
      @(posedge clk); #1 {resume_evt, detect_evt, plug_evt, done_b, done_a} = 5'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(4 * 20000);
      $display("FAIL watchdog: actual timeout expected finish");
      fails++; tests++;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      irq_chk(1'b0, "R1 irq after reset");
      rd_chk(8'h05, 8'h00, "R1 ctrl reset");
      rd_chk(8'h06, 8'h00, "R1 ien reset");
      rd_chk(8'h0D, 8'h00, "R1 status reset");
      rd_chk(8'h0E, 8'h00, "R1 reload lo reset");
      rd_chk(8'h0F, 8'h00, "R1 reload hi reset");

      wr_reg(8'h06, 8'hFF);
      rd_chk(8'h06, 8'h73, "R9 ien reserved bits");
      wr_reg(8'h05, 8'hFE);
      rd_chk(8'h05, 8'h40, "R9 ctrl reserved bits");
      wr_reg(8'h05, 8'h00);
      wr_reg(8'h06, 8'h00);
      rd_chk(8'h07, 8'h00, "R10 unmapped address reads 0");

      pulse(5'b00001);
      rd_chk(8'h0D, 8'h01, "R2 done_a sets bit0 while disabled");
      irq_chk(1'b0, "R3 disabled bit gives no irq");
      pulse(5'b00010);
      rd_chk(8'h0D, 8'h03, "R2 done_b sets bit1");
      wr_reg(8'h06, 8'h03);
      irq_chk(1'b1, "R3 irq on enabled status");
      wr_reg(8'h0D, 8'h00);
      rd_chk(8'h0D, 8'h03, "R4 write 0 keeps status");
      wr_reg(8'h0D, 8'h01);
      irq_chk(1'b1, "R3 irq held while one bit remains");
      rd_chk(8'h0D, 8'h02, "R4 write 1 clears bit0");
      wr_reg(8'h0D, 8'h02);
      irq_chk(1'b0, "R3 irq drops after last clear");

      done_a = 1'b1;
      wr_reg(8'h0D, 8'h01);
      done_a = 1'b0;
      rd_chk(8'h0D, 8'h01, "R5 event beats clear");
      wr_reg(8'h0D, 8'h01);

      pulse(5'b10000);
      rd_chk(8'h0D, 8'h00, "R6 resume ignored in detect mode");
      pulse(5'b01000);
      rd_chk(8'h0D, 8'h40, "R6 detect sets bit6");
      wr_reg(8'h0D, 8'h40);
      wr_reg(8'h05, 8'h40);
      pulse(5'b01000);
      rd_chk(8'h0D, 8'h00, "R6 detect ignored in resume mode");
      pulse(5'b10000);
      rd_chk(8'h0D, 8'h40, "R6 resume sets bit6");
      wr_reg(8'h0D, 8'h40);
      pulse(5'b00100);
      rd_chk(8'h0D, 8'h20, "R2 plug sets bit5");
      wr_reg(8'h0D, 8'h20);

      wr_reg(8'h0F, 8'hFF);
      rd_chk(8'h0F, 8'h3F, "R9 reload hi keeps six bits");
      wr_reg(8'h0F, 8'h00);
      wr_reg(8'h0E, 8'h03);
      rd_chk(8'h0E, 8'h03, "R10 reload lo");
      wr_reg(8'h06, 8'h10);
      wr_reg(8'h05, 8'h41);
      rd_chk(8'h0D, 8'h00, "R7 no event right after start");
      idle(2);
      rd_chk(8'h0D, 8'h00, "R7 no event before N+1 ticks");
      rd_chk(8'h0D, 8'h10, "R7 event after N+1 ticks");
      irq_chk(1'b1, "R7 sof raises irq");
      wr_reg(8'h0D, 8'h10);
      slow_tick = 1'b1;
      idle(30);
      slow_tick = 1'b0;

      wr_reg(8'h05, 8'h40);
      wr_reg(8'h0D, 8'h10);
      idle(10);
      rd_chk(8'h0D, 8'h00, "R8 stopped timer raises nothing");
      irq_chk(1'b0, "R8 irq low when stopped");
      wr_reg(8'h05, 8'h41);
      rd_chk(8'h0D, 8'h00, "R8 restart begins full period");
      idle(2);
      rd_chk(8'h0D, 8'h00, "R8 no early event after restart");
      rd_chk(8'h0D, 8'h10, "R8 event one period after restart");
      idle(20);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule